// File: doc/BRIEF.md
# 100BASE-X Receive Carrier Sense Detector

This block produces the carrier-sense indication for a 100 Mb/s receiver. Its input is the 4B/5B code stream after line decoding and descrambling, one code bit per clock. A tentative carrier comes up as soon as the line shows sparse zeros. This happens before any symbol boundary is known. While carrier is tentative, the block looks for the start-of-stream delimiter. A match fixes the 5-bit alignment. From then on the block inspects whole code groups until an end-of-stream pair or a pair of idles closes the carrier. If the tentative carrier sees a long run of ones before any delimiter, it is thrown away as a false start.

The receive carrier reaches the output one symbol time late. This lets the block confirm the closing symbol before carrier drops, so the falling edge lands at the end of /T/ or of the first IDLE in the delayed timeline. Transmit enable is merged into the output for half-duplex operation. Full-duplex or repeater operation uses receive activity alone.

Top module: `carrier_sense_det`

## Requirements
- R1: With all inputs idle, a zero bit raises receive carrier when another zero lies two to nine bits earlier. `crs_o` then goes high exactly five clocks after the clock that sampled the second zero.
- R2: A line of all ones never raises carrier, and neither does a lone pair of adjacent zeros surrounded by ones.
- R3: While carrier is tentative (no delimiter found), a tenth consecutive one drops `crs_o` right after the clock that samples it. `false_carrier_o` is high for exactly that one clock.
- R4: Fewer than ten consecutive ones in the tentative phase keep carrier. The 10 bits J=11000 followed by K=10001 (leftmost bit first on the wire) fix symbol alignment at the last K bit.
- R5: After alignment, T=01101 followed by R=00111 ends carrier. `crs_o` is still high after the fourth R bit and low after the fifth.
- R6: After alignment, two IDLE=11111 groups in a row end carrier. `crs_o` is still high after the fourth bit of the second IDLE and low after its fifth.
- R7: /T/ followed by a group other than R, and IDLE followed by a group other than IDLE, both leave carrier asserted.
- R8: `crs_o` equals receive carrier OR (`tx_en_i` AND NOT `full_duplex_i` AND NOT `repeater_i`).
- R9: Reset clears carrier, alignment and the bit history. The bit history is filled with ones, and `crs_o` and `false_carrier_o` read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one code bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_bit_i | input | 1 | Decoded, descrambled code bit |
| tx_en_i | input | 1 | Local transmit enable |
| full_duplex_i | input | 1 | Full-duplex operation |
| repeater_i | input | 1 | Repeater operation |
| crs_o | output | 1 | Carrier sense |
| false_carrier_o | output | 1 | One-clock pulse when a tentative carrier is aborted |

## Verification
The bench builds the block with its default parameters: a ten-bit ones limit and a five-clock output delay. With these values, the nine-versus-ten ones boundary takes only a few bits to reach. The exact rising and falling bit of the carrier can be predicted by counting bits from the delimiter. All eight combinations of transmit enable, duplex and repeater are swept, once with the receive side idle and once mid-frame. Frames close once by each termination rule and once after a non-matching second symbol, and a reset is applied in the middle of a frame.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int unsigned SYM_W = 5;
  localparam int unsigned WIN_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_ALIGN = 2'd2
  } csd_state_e;
endpackage

// File: rtl/csd_window.sv
module csd_window
  import csd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic             sparse_o,
  output logic             jk_o,
  output logic [SYM_W-1:0] sym_o
);
  logic [WIN_W-2:0] hist_q;
  logic [WIN_W-1:0] win;

  // newest bit at index 0
  assign win = {hist_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '1;
    else         hist_q <= win[WIN_W-2:0];
  end

  // new zero plus a non-adjacent zero inside the window
  assign sparse_o = ~bit_i & ~(&win[WIN_W-1:2]);
  assign jk_o     = (win == {CG_J, CG_K});
  assign sym_o    = win[SYM_W-1:0];
endmodule

// File: rtl/csd_track.sv
module csd_track
  import csd_pkg::*;
#(
  parameter int unsigned ONES_LIM = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             sparse_i,
  input  logic             jk_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             busy_o,
  output logic             stop_o,
  output logic             fc_o
);
  localparam int unsigned OW = $clog2(ONES_LIM);
  localparam int unsigned PW = $clog2(SYM_W);
  localparam logic [OW-1:0] ONES_LAST = OW'(ONES_LIM - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(SYM_W - 1);

  csd_state_e    state_q, state_d;
  logic [OW-1:0] ones_q, ones_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          pend_t_q, pend_t_d;
  logic          pend_i_q, pend_i_d;
  logic          fc_q;
  logic          abort, term;

  always_comb begin
    state_d  = state_q;
    ones_d   = ones_q;
    ph_d     = ph_q;
    pend_t_d = pend_t_q;
    pend_i_d = pend_i_q;
    abort    = 1'b0;
    term     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sparse_i) begin
          state_d = ST_PRE;
          ones_d  = '0;
        end
      end
      ST_PRE: begin
        if (jk_i) begin
          state_d  = ST_ALIGN;
          ph_d     = '0;
          pend_t_d = 1'b0;
          pend_i_d = 1'b0;
        end else if (bit_i) begin
          if (ones_q == ONES_LAST) begin
            abort   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ones_d = ones_q + 1'b1;
          end
        end else begin
          ones_d = '0;
        end
      end
      ST_ALIGN: begin
        if (ph_q == PH_LAST) begin
          ph_d = '0;
          if ((pend_t_q && sym_i == CG_R) || (pend_i_q && sym_i == CG_IDLE)) begin
            term    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            pend_t_d = (sym_i == CG_T);
            pend_i_d = (sym_i == CG_IDLE);
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ones_q   <= '0;
      ph_q     <= '0;
      pend_t_q <= 1'b0;
      pend_i_q <= 1'b0;
      fc_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      ones_q   <= ones_d;
      ph_q     <= ph_d;
      pend_t_q <= pend_t_d;
      pend_i_q <= pend_i_d;
      fc_q     <= abort;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign stop_o = abort | term;
  assign fc_o   = fc_q;
endmodule

// File: rtl/csd_delay.sv
module csd_delay #(
  parameter int unsigned DLY_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic clr_i,
  output logic out_o
);
  logic [DLY_LEN-1:0] dly_q;

  // clear on a confirmed end so the edge lands on the closing symbol
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dly_q <= '0;
    else if (clr_i) dly_q <= '0;
    else            dly_q <= {dly_q[DLY_LEN-2:0], in_i};
  end

  assign out_o = dly_q[DLY_LEN-1];
endmodule

// File: rtl/carrier_sense_det.sv
module carrier_sense_det
  import csd_pkg::*;
#(
  parameter int unsigned ONES_LIM = 10,
  parameter int unsigned DLY_LEN  = SYM_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic code_bit_i,
  input  logic tx_en_i,
  input  logic full_duplex_i,
  input  logic repeater_i,
  output logic crs_o,
  output logic false_carrier_o
);
  logic             sparse, jk;
  logic [SYM_W-1:0] sym;
  logic             rx_busy, rx_stop, rx_crs;

  csd_window i_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (code_bit_i),
    .sparse_o (sparse),
    .jk_o     (jk),
    .sym_o    (sym)
  );

  csd_track #(.ONES_LIM(ONES_LIM)) i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (code_bit_i),
    .sparse_i (sparse),
    .jk_i     (jk),
    .sym_i    (sym),
    .busy_o   (rx_busy),
    .stop_o   (rx_stop),
    .fc_o     (false_carrier_o)
  );

  csd_delay #(.DLY_LEN(DLY_LEN)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (rx_busy),
    .clr_i  (rx_stop),
    .out_o  (rx_crs)
  );

  assign crs_o = rx_crs | (tx_en_i & ~full_duplex_i & ~repeater_i);
endmodule

// File: rtl/csd_checker.sv
module csd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic rx_crs_i,
  input logic crs_i,
  input logic fc_i,
  input logic tx_en_i,
  input logic full_duplex_i,
  input logic repeater_i
);
  a_r3_fc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_i |=> !fc_i);

  a_r3_fc_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_i |-> (!rx_crs_i && !busy_i));

  a_r3_fc_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_i |-> $past(busy_i));

  a_r1_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_crs_i |-> $past(busy_i, 5));

  a_r8_half_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !full_duplex_i && !repeater_i) |-> crs_i);

  a_r8_rx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i || repeater_i) |-> (crs_i == rx_crs_i));
endmodule

bind carrier_sense_det csd_checker i_csd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (rx_busy),
  .rx_crs_i      (rx_crs),
  .crs_i         (crs_o),
  .fc_i          (false_carrier_o),
  .tx_en_i       (tx_en_i),
  .full_duplex_i (full_duplex_i),
  .repeater_i    (repeater_i)
);

// File: tb/test_carrier_sense_det.sv
`timescale 1ns/1ps
module test_carrier_sense_det;
  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111, I = 5'b11111;
  localparam logic [4:0] D1 = 5'b10101, D2 = 5'b01011, D3 = 5'b11010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_bit = 1'b1;
  logic tx_en = 1'b0, fdx = 1'b0, rep = 1'b0;
  logic crs, fc;

  int n_chk = 0, n_bad = 0;
  int fc_cnt = 0, hi_cnt = 0;
  logic crs_s, fc_s;
  logic sc [5];
  bit done = 1'b0;

  always #5 clk = ~clk;

  carrier_sense_det i_carrier_sense_det (
    .clk_i(clk), .rst_ni(rst_n), .code_bit_i(code_bit), .tx_en_i(tx_en),
    .full_duplex_i(fdx), .repeater_i(rep), .crs_o(crs), .false_carrier_o(fc)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    code_bit = b;
    @(posedge clk);
    #1;
    crs_s = crs;
    fc_s  = fc;
    if (fc) fc_cnt++;
    if (crs) hi_cnt++;
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) begin
      send_bit(s[i]);
      sc[4-i] = crs_s;
    end
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "crs in reset", crs, 1'b0);
    chk("R9", "false carrier in reset", fc, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: no carrier from ones or an adjacent zero pair
    hi_cnt = 0;
    ones(30);
    send_bit(1'b0); send_bit(1'b0);
    ones(12);
    chk_int("R2", "crs high cycles", hi_cnt, 0);
    chk_int("R2", "false carrier pulses", fc_cnt, 0);

    // R1/R4/R5: frame closed by T R
    ones(12);
    send_sym(J);
    chk("R1", "crs after J", sc[4], 1'b0);
    send_sym(K);
    chk("R1", "crs after K bit3", sc[3], 1'b0);
    chk("R1", "crs after K bit4", sc[4], 1'b1);
    send_sym(D1); send_sym(D2); send_sym(D3);
    chk("R4", "crs held over data", sc[4], 1'b1);
    send_sym(T);
    chk("R5", "crs through T", sc[4], 1'b1);
    send_sym(R);
    chk("R5", "crs at R bit3", sc[3], 1'b1);
    chk("R5", "crs at R bit4", sc[4], 1'b0);
    hi_cnt = 0;
    ones(12);
    chk_int("R5", "crs high after end", hi_cnt, 0);

    // R6: frame closed by two idles
    send_sym(J); send_sym(K); send_sym(D1);
    send_sym(I);
    chk("R6", "crs after first IDLE", sc[4], 1'b1);
    send_sym(I);
    chk("R6", "crs at IDLE2 bit3", sc[3], 1'b1);
    chk("R6", "crs at IDLE2 bit4", sc[4], 1'b0);
    ones(12);

    // R7: unmatched second symbols keep carrier
    send_sym(J); send_sym(K); send_sym(D1);
    send_sym(T); send_sym(D2);
    chk("R7", "crs after T then data", sc[4], 1'b1);
    send_sym(I); send_sym(D3);
    chk("R7", "crs after IDLE then data", sc[4], 1'b1);
    send_sym(T); send_sym(T);
    chk("R7", "crs after T then T", sc[4], 1'b1);
    send_sym(R);
    chk("R5", "crs after T T R", sc[4], 1'b0);
    ones(12);

    // R3: false start aborted by ten ones
    fc_cnt = 0;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    ones(9);
    chk("R3", "crs after nine ones", crs_s, 1'b1);
    chk("R3", "no pulse after nine ones", fc_s, 1'b0);
    send_bit(1'b1);
    chk("R3", "crs at tenth one", crs_s, 1'b0);
    chk("R3", "pulse at tenth one", fc_s, 1'b1);
    send_bit(1'b1);
    chk("R3", "pulse width", fc_s, 1'b0);
    chk_int("R3", "pulse count", fc_cnt, 1);
    ones(12);

    // R4: short ones run then J K aligns
    fc_cnt = 0;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    ones(7);
    send_sym(J); send_sym(K); send_sym(D1);
    chk("R4", "crs kept after short run", sc[4], 1'b1);
    send_sym(T); send_sym(R);
    chk("R4", "aligned end at R bit4", sc[4], 1'b0);
    chk_int("R4", "no false carrier", fc_cnt, 0);
    ones(12);

    // R8: mode sweep, receive idle
    for (int m = 0; m < 8; m++) begin
      tx_en = m[0]; fdx = m[1]; rep = m[2];
      send_bit(1'b1);
      chk("R8", $sformatf("idle rx mode %0d", m), crs_s, m[0] & ~m[1] & ~m[2]);
    end
    tx_en = 0; fdx = 0; rep = 0;
    ones(12);

    // R8: mode sweep, receive active
    send_sym(J); send_sym(K);
    for (int m = 0; m < 8; m++) begin
      tx_en = m[0]; fdx = m[1]; rep = m[2];
      send_sym(D1);
      chk("R8", $sformatf("active rx mode %0d", m), sc[4], 1'b1);
    end
    tx_en = 0; fdx = 0; rep = 0;
    send_sym(T); send_sym(R);
    chk("R8", "crs after frame end", sc[4], 1'b0);
    ones(12);

    // R9: reset in mid-frame
    send_sym(J); send_sym(K); send_sym(D1);
    chk("R9", "crs before reset", sc[4], 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "crs during reset", crs, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    hi_cnt = 0;
    ones(12);
    chk_int("R9", "crs high after reset", hi_cnt, 0);
    send_sym(J); send_sym(K);
    chk("R9", "fresh frame after reset", sc[4], 1'b1);
    send_sym(T); send_sym(R);
    chk("R9", "fresh frame end", sc[4], 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule